// File: doc/BRIEF.md
# Lockable ROM Array Bus Interface

This block sits between a processor-side request stream and a small on-chip read-only array that is organised as 16-bit words. It takes one read request at a time: a byte address, an access size (byte, word or long word) and a flag that says whether the access is a program fetch or a data read. It reads the array in one or two bus halves and returns the right-aligned, big-endian result on a response stream. A byte or an even-addressed word needs one half. A long word or an odd-addressed word needs two halves, read at ascending word addresses. Each half lasts a number of bus cycles chosen by a wait field, and one bus cycle is two clocks.

A 5-bit configuration register holds a lock bit, a space field and the wait field. Once the lock bit is set, the register is frozen until reset. When program-only mode is selected, a data-space request is taken and then dropped: it gets no response, and the data bus stays at zero.

Both streams use valid/ready. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the block is idle, so a new request waits until the previous response has been taken. A response is offered with `rsp_valid` and held, with unchanged data, until a clock edge where `rsp_ready` is high.

Top module: `rom_port_ctrl`

## Requirements
- R1: After reset `cfg_rdata` reads {lock=0, space=DEF_SPACE, wait=DEF_WAIT}. It always reads back the register as bit 4 = lock, bits 3:2 = space, bits 1:0 = wait. After reset `req_ready` is 1 and `rsp_valid` is 0.
- R2: A write with bit 4 set, made while the lock is clear, sets the lock. The lock then stays set until reset, and a later write of 0 to bit 4 does not clear it.
- R3: While the lock is clear, a write (`cfg_we`=1) loads all five bits from `cfg_wdata` on that clock edge. While the lock is set, writes change nothing.
- R4: When space bit 2 is 1, a request with `req_prog`=0 is accepted and then discarded. No `rsp_valid` follows, `rsp_data` stays 0, and `req_ready` stays high. Space bit 3 has no effect: with bit 2 clear, data requests are served.
- R5: Each half lasts 2*(W+2) clocks, where W is the wait field (0..3 gives 2..5 bus cycles). `rsp_valid` rises H*2*(W+2) clock edges after the accepting edge, where H is the number of halves.
- R6: `req_size` 00 is a byte, 01 is a word, and 1x is a long word. A byte or an even-addressed word takes one half. An odd-addressed word or any long word takes two halves.
- R7: Array word w (the index modulo the array depth, 64 words by default) holds {(3*w+1) mod 256, w XOR 8'h5A}, and an even byte address selects the high byte. The results are:
  - a byte returns {24'b0, byte(a)};
  - an even word returns {16'b0, word(a/2)};
  - an odd word returns {16'b0, byte(a), byte(a+1)};
  - a long word ignores address bit 0 and returns {word(a/2), word(a/2+1)}.
  
  Word indices wrap.
- R8: While `rsp_valid`=1 and `rsp_ready`=0, `rsp_valid` and `rsp_data` hold. `rsp_data` is 0 whenever `rsp_valid` is 0.
- R9: The wait and space settings are sampled on the accepting edge. A configuration write on that same edge affects only later requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 5 | Configuration write value {lock, space[1:0], wait[1:0]} |
| cfg_rdata | output | 5 | Current configuration register contents |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Block can take a request |
| req_addr | input | ADDR_W | Byte address of the request |
| req_size | input | 2 | 00 byte, 01 word, 1x long word |
| req_prog | input | 1 | 1 = program-space access, 0 = data-space access |
| rsp_valid | output | 1 | Read result valid |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_data | output | 32 | Right-aligned read result, 0 when not valid |

## Verification
Two events can land on the same clock edge: a configuration write and the acceptance of a request. The bench provokes this by raising `cfg_we` and `req_valid` together while the block is idle, with the write changing the wait field. It judges the result by requiring that the response latency matches the old wait setting and that a readback afterwards shows the new value. In a second case, the lock bit is set and then a clearing write is attempted; the bench checks both the readback and the still-active program-only filter.

// File: rtl/rom_port_pkg.sv
package rom_port_pkg;

  typedef struct packed {
    logic       lock;
    logic [1:0] space;
    logic [1:0] wsel;
  } cfg_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_RESP = 2'd2
  } seq_st_t;

  // Content rule of the array: high byte 3*i+1, low byte i xor 5A.
  function automatic logic [15:0] rom_word(input logic [7:0] i);
    logic [7:0] hi;
    hi = i * 8'd3 + 8'd1;
    return {hi, i ^ 8'h5A};
  endfunction

endpackage

// File: rtl/rom_cfg_reg.sv
module rom_cfg_reg
  import rom_port_pkg::*;
#(
  parameter logic [1:0] DEF_SPACE = 2'b00,
  parameter logic [1:0] DEF_WAIT  = 2'b00
) (
  input  logic clk,
  input  logic rst_n,
  input  logic we,
  input  cfg_t wdata,
  output cfg_t cfg_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q.lock  <= 1'b0;
      cfg_q.space <= DEF_SPACE;
      cfg_q.wsel  <= DEF_WAIT;
    end else if (we && !cfg_q.lock) begin
      cfg_q <= wdata;
    end
  end

  // R2: once set, the lock stays set until reset
  a_r2_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q.lock |=> cfg_q.lock);

  // R3: a locked register never changes
  a_r3_frozen_fields: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q.lock |=> $stable(cfg_q));

endmodule

// File: rtl/rom_table.sv
module rom_table
  import rom_port_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic [IDX_W-1:0] idx,
  output logic [15:0]      word
);

  logic [7:0] idx8;

  generate
    if (IDX_W < 8) begin : g_pad
      assign idx8 = {{(8-IDX_W){1'b0}}, idx};
    end else begin : g_trunc
      assign idx8 = idx[7:0];
    end
  endgenerate

  assign word = rom_word(idx8);

endmodule

// File: rtl/rom_access_seq.sv
module rom_access_seq
  import rom_port_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int IDX_W  = ADDR_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              req_prog,
  input  logic              prog_only,
  input  logic [1:0]        cfg_wsel,
  output logic [IDX_W-1:0]  rd_idx,
  input  logic [15:0]       rd_word,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [31:0]       rsp_data
);

  localparam int CNT_W  = 4;
  localparam int DATA_W = 32;

  seq_st_t           st_q;
  logic [ADDR_W-1:0] addr_q;
  logic              long_q, word_q, split_q, half_q;
  logic [1:0]        wsel_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] acc_q;

  logic              accept, blocked, req_split, narrow, last_half;
  logic [7:0]        piece8;
  logic [DATA_W-1:0] acc_next;

  // Last count value of one half: 2*(w+2) clocks minus one.
  function automatic logic [CNT_W-1:0] half_last(input logic [1:0] w);
    return CNT_W'({w, 1'b1}) + CNT_W'(2);
  endfunction

  assign req_ready = (st_q == ST_IDLE);
  assign accept    = req_valid & req_ready;
  assign blocked   = prog_only & ~req_prog;
  assign req_split = req_size[1] | ((req_size == 2'b01) & req_addr[0]);

  assign narrow    = ~long_q & (~word_q | addr_q[0]);
  assign last_half = ~split_q | half_q;
  assign rd_idx    = addr_q[ADDR_W-1:1] + IDX_W'(half_q);
  assign piece8    = (addr_q[0] ^ half_q) ? rd_word[7:0] : rd_word[15:8];
  assign acc_next  = narrow ? {acc_q[DATA_W-9:0], piece8}
                            : {acc_q[DATA_W-17:0], rd_word};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      addr_q  <= '0;
      long_q  <= 1'b0;
      word_q  <= 1'b0;
      split_q <= 1'b0;
      half_q  <= 1'b0;
      wsel_q  <= '0;
      cnt_q   <= '0;
      acc_q   <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (accept && !blocked) begin
            st_q    <= ST_BUSY;
            addr_q  <= req_addr;
            long_q  <= req_size[1];
            word_q  <= ~req_size[1] & req_size[0];
            split_q <= req_split;
            half_q  <= 1'b0;
            wsel_q  <= cfg_wsel;
            cnt_q   <= half_last(cfg_wsel);
            acc_q   <= '0;
          end
        end
        ST_BUSY: begin
          if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
          end else begin
            acc_q <= acc_next;
            if (last_half) begin
              st_q <= ST_RESP;
            end else begin
              half_q <= 1'b1;
              cnt_q  <= half_last(wsel_q);
            end
          end
        end
        ST_RESP: begin
          if (rsp_ready) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign rsp_valid = (st_q == ST_RESP);
  assign rsp_data  = rsp_valid ? acc_q : '0;

  // R8: a stalled response holds its data
  a_r8_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));

  // R4: a filtered data access leaves the block idle with no response
  a_r4_drop_filtered: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && prog_only && !req_prog |=> !rsp_valid && req_ready);

  // R5: the half counter never exceeds the length of a half
  a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_BUSY) |-> (cnt_q <= half_last(wsel_q)));

  // R9: the wait setting of an access in flight does not move
  a_r9_wait_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_BUSY) |=> $stable(wsel_q));

endmodule

// File: rtl/rom_port_ctrl.sv
module rom_port_ctrl
  import rom_port_pkg::*;
#(
  parameter int         ADDR_W    = 7,
  parameter logic [1:0] DEF_SPACE = 2'b00,
  parameter logic [1:0] DEF_WAIT  = 2'b00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [4:0]        cfg_wdata,
  output logic [4:0]        cfg_rdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              req_prog,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [31:0]       rsp_data
);

  localparam int IDX_W = ADDR_W - 1;

  cfg_t             cfg_q;
  cfg_t             cfg_wr;
  logic [IDX_W-1:0] rd_idx;
  logic [15:0]      rd_word;

  assign cfg_wr    = cfg_t'(cfg_wdata);
  assign cfg_rdata = cfg_q;

  rom_cfg_reg #(
    .DEF_SPACE (DEF_SPACE),
    .DEF_WAIT  (DEF_WAIT)
  ) u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .wdata (cfg_wr),
    .cfg_q (cfg_q)
  );

  rom_table #(
    .IDX_W (IDX_W)
  ) u_table (
    .idx  (rd_idx),
    .word (rd_word)
  );

  rom_access_seq #(
    .ADDR_W (ADDR_W),
    .IDX_W  (IDX_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .req_size  (req_size),
    .req_prog  (req_prog),
    .prog_only (cfg_q.space[0]),
    .cfg_wsel  (cfg_q.wsel),
    .rd_idx    (rd_idx),
    .rd_word   (rd_word),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_data  (rsp_data)
  );

endmodule

// File: tb/rom_port_ctrl_bench.sv
`timescale 1ns/1ps
module rom_port_ctrl_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_wdata = '0;
  logic [4:0]  cfg_rdata;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [6:0]  req_addr = '0;
  logic [1:0]  req_size = '0;
  logic        req_prog = 1'b1;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_data;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  logic       m_lock = 1'b0;
  logic [1:0] m_space = 2'b00;
  logic [1:0] m_wait = 2'b00;

  typedef struct {
    logic [31:0] data;
    int          acc;
    int          lat;
    int          stall;
    string       tag;
  } exp_t;
  exp_t q[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rom_port_ctrl u_rom_port_ctrl (
    .clk (clk), .rst_n (rst_n),
    .cfg_we (cfg_we), .cfg_wdata (cfg_wdata), .cfg_rdata (cfg_rdata),
    .req_valid (req_valid), .req_ready (req_ready), .req_addr (req_addr),
    .req_size (req_size), .req_prog (req_prog),
    .rsp_valid (rsp_valid), .rsp_ready (rsp_ready), .rsp_data (rsp_data)
  );

  task automatic chk(input logic ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Expected array contents, from R7
  function automatic logic [15:0] bw(input int w);
    int k;
    logic [7:0] h;
    k = w % 64;
    h = 8'(k * 3 + 1);
    return {h, 8'(k) ^ 8'h5A};
  endfunction

  function automatic logic [7:0] bb(input int a);
    logic [15:0] x;
    x = bw((a % 128) / 2);
    return (a % 2 == 1) ? x[7:0] : x[15:8];
  endfunction

  function automatic logic [31:0] expd(input int a, input logic [1:0] sz);
    if (sz == 2'b00) return {24'b0, bb(a)};
    if (sz == 2'b01 && a % 2 == 0) return {16'b0, bw(a / 2)};
    if (sz == 2'b01) return {16'b0, bb(a), bb(a + 1)};
    return {bw(a / 2), bw(a / 2 + 1)};
  endfunction

  task automatic cfg_write(input logic [4:0] v);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
    if (!m_lock) {m_lock, m_space, m_wait} = v;
  endtask

  // Driver: issues one request, optionally with a same-edge config write
  task automatic issue(input int a, input logic [1:0] sz, input logic prog,
                       input int stall, input string tag,
                       input logic wr, input logic [4:0] wv);
    logic ok;
    int halves;
    exp_t e;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_addr = 7'(a);
    req_size = sz;
    req_prog = prog;
    if (wr) begin
      cfg_we = 1'b1;
      cfg_wdata = wv;
    end
    ok = !(m_space[0] && !prog);
    halves = (sz[1] || (sz == 2'b01 && a % 2 == 1)) ? 2 : 1;
    if (ok) begin
      e.data = expd(a, sz);
      e.acc = cyc + 1;
      e.lat = 2 * (int'(m_wait) + 2) * halves;
      e.stall = stall;
      e.tag = tag;
      q.push_back(e);
    end
    @(negedge clk);
    req_valid = 1'b0;
    cfg_we = 1'b0;
    if (wr && !m_lock) {m_lock, m_space, m_wait} = wv;
    if (!ok) begin
      repeat (12) @(negedge clk);
      chk(!rsp_valid && rsp_data == 32'h0 && req_ready,
          {"R4 filtered data access ", tag},
          {rsp_valid, req_ready, rsp_data[29:0]}, 32'h4000_0000);
    end
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // Monitor / scoreboard
  int  stall_left = 0;
  bit  seen = 0;
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (q.size() == 0) begin
        chk(1'b0, "R4 unexpected response", rsp_data, 32'h0);
      end else begin
        if (!seen) begin
          seen = 1;
          stall_left = q[0].stall;
          chk(rsp_data == q[0].data, {"R7 data ", q[0].tag}, rsp_data, q[0].data);
          chk((cyc - q[0].acc) == q[0].lat, {"R5 latency ", q[0].tag},
              32'(cyc - q[0].acc), 32'(q[0].lat));
        end else begin
          chk(rsp_data == q[0].data, {"R8 held data ", q[0].tag}, rsp_data, q[0].data);
        end
        rsp_ready = (stall_left == 0);
        if (stall_left > 0) stall_left--;
        if (rsp_ready) begin
          void'(q.pop_front());
          seen = 0;
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired act=%0d exp=0", q.size());
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(cfg_rdata == 5'b0_00_00, "R1 reset config", 32'(cfg_rdata), 32'h0);
    chk(req_ready && !rsp_valid && rsp_data == 0, "R1 reset handshake",
        {30'b0, req_ready, rsp_valid}, 32'h2);

    // R6/R7 sizes and alignments at wait 0
    issue(0,   2'b00, 1'b1, 0, "R6 byte even", 0, 0);
    issue(5,   2'b00, 1'b0, 0, "R7 byte odd data space", 0, 0);
    issue(16,  2'b01, 1'b1, 0, "R6 word aligned", 0, 0);
    issue(17,  2'b01, 1'b1, 0, "R6 word misaligned", 0, 0);
    issue(32,  2'b10, 1'b1, 0, "R6 long aligned", 0, 0);
    issue(33,  2'b11, 1'b1, 0, "R7 long bit0 ignored", 0, 0);
    issue(127, 2'b01, 1'b1, 0, "R7 word wrap", 0, 0);
    issue(126, 2'b10, 1'b1, 0, "R7 long wrap", 0, 0);
    drain();

    // R3 unlocked write, R5 longest wait
    cfg_write(5'b0_00_11);
    chk(cfg_rdata == 5'b0_00_11, "R3 unlocked write", 32'(cfg_rdata), 32'h03);
    issue(51, 2'b00, 1'b1, 0, "R5 byte wait 3", 0, 0);
    issue(8,  2'b10, 1'b0, 0, "R5 long wait 3", 0, 0);
    // R8 back-pressure
    issue(10, 2'b01, 1'b1, 3, "R8 stalled word", 0, 0);
    drain();

    // R9 config write on the accepting edge
    issue(18, 2'b01, 1'b1, 0, "R9 same-edge write", 1, 5'b0_00_01);
    drain();
    chk(cfg_rdata == 5'b0_00_01, "R9 write landed", 32'(cfg_rdata), 32'h01);
    issue(19, 2'b01, 1'b1, 0, "R9 next request uses new wait", 0, 0);
    drain();

    // R4 program-only filter and don't-care upper bit
    cfg_write(5'b0_01_01);
    issue(4, 2'b00, 1'b0, 0, "data blocked", 0, 0);
    issue(4, 2'b01, 1'b1, 0, "R4 program allowed", 0, 0);
    drain();
    cfg_write(5'b0_10_00);
    issue(9, 2'b01, 1'b0, 0, "R4 upper bit ignored", 0, 0);
    drain();

    // R2 lock and R3 frozen fields
    cfg_write(5'b1_01_10);
    chk(cfg_rdata == 5'b1_01_10, "R2 lock set", 32'(cfg_rdata), 32'h16);
    cfg_write(5'b0_00_00);
    chk(cfg_rdata == 5'b1_01_10, "R2 R3 locked write ignored", 32'(cfg_rdata), 32'h16);
    issue(6, 2'b10, 1'b0, 0, "locked still program-only", 0, 0);
    issue(2, 2'b10, 1'b1, 0, "R5 long wait 2 locked", 0, 0);
    drain();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule